// File: doc/BRIEF.md
# Reset-Phase Boot Mode Capture

This block watches the external reset pin of the chip, runs a small reset phase sequencer and delivers a two-bit boot mode to the boot logic. While the reset pin is held low, the two boot strap pins are sampled on every cycle of the internal 16 MHz RC clock. The synchronized release of the pin is stretched by an internal counter into an effective release, and sampling stops a fixed number of cycles before that effective release. The frozen value is copied to the boot mode output on the cycle the sequencer enters its third phase.

Reset sequences that come from internal sources do not all touch the pin. A per-source mask chooses which internal requests pull the reset pin low for a set number of cycles. Those requests therefore cause a fresh capture of the strap pins. Requests that leave the pin alone run the phase sequence again and reuse the boot mode that is already held. After power-on the boot mode has a defined default, so it is never unknown.

Top module: `bootmode_capture_top`

## Requirements
- R1: During and right after the synchronous power-on reset `rst`, `boot_mode` is 2'b00, `ext_rst_drive` is 0 and `reset_phase` is 1. With no further request the sequencer then returns to `reset_phase` 0.
- R2: While the synchronized reset pin is low, the strap pins are sampled every cycle. A strap value held steady across the whole assertion and its release is the one that is captured.
- R3: Sampling stops LEAD (5) cycles before the effective release, which comes STRETCH (16) cycles after the synchronized pin release. With the defaults, a strap change 8 cycles after the pin rises is captured, and a change 14 cycles after is ignored.
- R4: `boot_mode` changes only on the cycle `reset_phase` goes from 2 to 3, and it takes the captured value. Through phases 1 and 2 it keeps its previous value.
- R5: An internal request whose mask bit is 0 restarts the sequence (`reset_phase` goes to 1 on the next cycle) and leaves `ext_rst_drive` at 0. The held `boot_mode` is kept even if the strap pins now differ.
- R6: An internal request whose mask bit is 1 asserts `ext_rst_drive` (1 = pull the pin low) for DRIVE_LEN (8) cycles from the next cycle on. That pulls the pin low, so the strap pins are captured again and reach `boot_mode`.
- R7: Phase encoding is 0 = run, 1 = phase 1, 2 = phase 2, 3 = phase 3. After the effective release the sequencer passes through 1, 2, 3 in that order, each for at least 4 cycles, and then settles at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz internal RC clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_rst_pin_n | input | 1 | Sensed level of the external reset pin, low = asserted |
| int_rst_req | input | NUM_SRC | Internal reset requests, one bit per source |
| pin_drive_mask | input | NUM_SRC | 1 = that source pulls the external pin low |
| boot_pins | input | 2 | Boot strap pins |
| boot_mode | output | 2 | Boot mode handed to the boot logic |
| reset_phase | output | 2 | Current reset phase (0 run, 1..3 phases) |
| ext_rst_drive | output | 1 | 1 = drive the external reset pin low |

## Verification
The assertions assume that the strap and reset pins reach the block through its own synchronizers, and that internal requests are clean pulses on clock edges. The bench drives every input at the falling edge and models the pad as the wired-AND of its own pin level with the inverse of `ext_rst_drive`. This keeps the pin feedback loop consistent with a real open-drain pad. Strap changes are placed several cycles away from the freeze point, so a capture or a miss never depends on a one-cycle race.

// File: rtl/bootcap_pkg.sv
package bootcap_pkg;

    typedef enum logic [1:0] {
        PH_RUN   = 2'd0,
        PH_ONE   = 2'd1,
        PH_TWO   = 2'd2,
        PH_THREE = 2'd3
    } rst_phase_e;

    typedef logic [1:0] boot_mode_t;

    typedef struct packed {
        logic       eff_rst;
        logic       sampling;
        boot_mode_t mode;
    } cap_state_t;

    function automatic int bc_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bc_sync2.sv
module bc_sync2 #(
    parameter int                 WIDTH   = 1,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[i] <= RST_VAL[i];
                stage2[i] <= RST_VAL[i];
            end else begin
                stage1[i] <= d_in[i];
                stage2[i] <= stage1[i];
            end
        end
    end

    assign d_out = stage2;
endmodule

// File: rtl/bc_release_stretch.sv
module bc_release_stretch
    import bootcap_pkg::*;
#(
    parameter int         STRETCH      = 16,
    parameter int         LEAD         = 5,
    parameter boot_mode_t DEFAULT_MODE = 2'b00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_asserted,
    input  boot_mode_t pins_sync,
    output cap_state_t cap
);
    localparam int              CW        = $clog2(STRETCH + 1);
    localparam logic [CW-1:0]   STRETCH_V = CW'(STRETCH);
    localparam logic [CW-1:0]   LEAD_V    = CW'(LEAD);

    logic [CW-1:0] hold_cnt;
    boot_mode_t    cap_q;
    logic          eff_rst;
    logic          sample_en;

    assign eff_rst   = pin_asserted || (hold_cnt != '0);
    assign sample_en = pin_asserted || (hold_cnt > LEAD_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
        end else if (pin_asserted) begin
            hold_cnt <= STRETCH_V;
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= DEFAULT_MODE;
        end else if (sample_en) begin
            cap_q <= pins_sync;
        end
    end

    assign cap = '{eff_rst: eff_rst, sampling: sample_en, mode: cap_q};

    a_r2_sample_while_low: assert property (@(posedge clk) disable iff (rst)
        pin_asserted |=> (cap_q == $past(pins_sync)));

    a_r3_frozen_near_release: assert property (@(posedge clk) disable iff (rst)
        (!pin_asserted && hold_cnt != '0 && hold_cnt <= LEAD_V) |=> $stable(cap_q));

    a_r3_stretch_reload: assert property (@(posedge clk) disable iff (rst)
        $fell(pin_asserted) |-> (hold_cnt == STRETCH_V));
endmodule

// File: rtl/bc_phase_seq.sv
module bc_phase_seq
    import bootcap_pkg::*;
#(
    parameter int NUM_SRC   = 4,
    parameter int PH1_MIN   = 4,
    parameter int PH2_LEN   = 4,
    parameter int PH3_LEN   = 4,
    parameter int DRIVE_LEN = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               eff_rst,
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] mask,
    output rst_phase_e         phase,
    output logic               enter_ph3,
    output logic               pin_drive
);
    localparam int            TMAX  = bc_max(bc_max(PH1_MIN, PH2_LEN), PH3_LEN);
    localparam int            TW    = $clog2(TMAX + 1);
    localparam int            DW    = $clog2(DRIVE_LEN + 1);
    localparam logic [TW-1:0] P1_END = TW'(PH1_MIN - 1);
    localparam logic [TW-1:0] P2_END = TW'(PH2_LEN - 1);
    localparam logic [TW-1:0] P3_END = TW'(PH3_LEN - 1);
    localparam logic [DW-1:0] DRV_V  = DW'(DRIVE_LEN);

    rst_phase_e    st;
    logic [TW-1:0] tmr;
    logic [DW-1:0] drv_cnt;
    logic [NUM_SRC-1:0] pin_src;
    logic          req_any;
    logic          req_pin;
    logic          hold;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign pin_src[s] = req[s] & mask[s];
    end

    assign req_any   = |req;
    assign req_pin   = |pin_src;
    assign hold      = eff_rst || req_any || (drv_cnt != '0);
    assign enter_ph3 = !hold && (st == PH_TWO) && (tmr == P2_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_cnt <= '0;
        end else if (req_pin) begin
            drv_cnt <= DRV_V;
        end else if (drv_cnt != '0) begin
            drv_cnt <= drv_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PH_ONE;
            tmr <= '0;
        end else if (hold) begin
            st  <= PH_ONE;
            tmr <= '0;
        end else begin
            unique case (st)
                PH_ONE: begin
                    if (tmr == P1_END) begin st <= PH_TWO; tmr <= '0; end
                    else tmr <= tmr + 1'b1;
                end
                PH_TWO: begin
                    if (tmr == P2_END) begin st <= PH_THREE; tmr <= '0; end
                    else tmr <= tmr + 1'b1;
                end
                PH_THREE: begin
                    if (tmr == P3_END) begin st <= PH_RUN; tmr <= '0; end
                    else tmr <= tmr + 1'b1;
                end
                default: tmr <= '0;
            endcase
        end
    end

    assign phase     = st;
    assign pin_drive = (drv_cnt != '0);

    a_r6_drive_only_in_ph1: assert property (@(posedge clk) disable iff (rst)
        pin_drive |-> (st == PH_ONE));

    a_r7_ph2_successor: assert property (@(posedge clk) disable iff (rst)
        (st == PH_TWO) |=> (st == PH_TWO || st == PH_THREE || st == PH_ONE));

    a_r5_request_restarts: assert property (@(posedge clk) disable iff (rst)
        req_any |=> (st == PH_ONE));
endmodule

// File: rtl/bootmode_capture_top.sv
module bootmode_capture_top
    import bootcap_pkg::*;
#(
    parameter int         NUM_SRC      = 4,
    parameter int         STRETCH      = 16,
    parameter int         LEAD         = 5,
    parameter int         PH1_MIN      = 4,
    parameter int         PH2_LEN      = 4,
    parameter int         PH3_LEN      = 4,
    parameter int         DRIVE_LEN    = 8,
    parameter boot_mode_t DEFAULT_MODE = 2'b00
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ext_rst_pin_n,
    input  logic [NUM_SRC-1:0] int_rst_req,
    input  logic [NUM_SRC-1:0] pin_drive_mask,
    input  logic [1:0]         boot_pins,
    output logic [1:0]         boot_mode,
    output logic [1:0]         reset_phase,
    output logic               ext_rst_drive
);
    logic       pin_n_s;
    boot_mode_t pins_s;
    cap_state_t cap;
    rst_phase_e phase;
    logic       enter_ph3;

    bc_sync2 #(.WIDTH(1), .RST_VAL(1'b1)) u_pin_sync (
        .clk(clk), .rst(rst), .d_in(ext_rst_pin_n), .d_out(pin_n_s)
    );

    bc_sync2 #(.WIDTH(2), .RST_VAL(2'b00)) u_strap_sync (
        .clk(clk), .rst(rst), .d_in(boot_pins), .d_out(pins_s)
    );

    bc_release_stretch #(
        .STRETCH(STRETCH), .LEAD(LEAD), .DEFAULT_MODE(DEFAULT_MODE)
    ) u_stretch (
        .clk(clk), .rst(rst), .pin_asserted(!pin_n_s),
        .pins_sync(pins_s), .cap(cap)
    );

    bc_phase_seq #(
        .NUM_SRC(NUM_SRC), .PH1_MIN(PH1_MIN), .PH2_LEN(PH2_LEN),
        .PH3_LEN(PH3_LEN), .DRIVE_LEN(DRIVE_LEN)
    ) u_seq (
        .clk(clk), .rst(rst), .eff_rst(cap.eff_rst), .req(int_rst_req),
        .mask(pin_drive_mask), .phase(phase), .enter_ph3(enter_ph3),
        .pin_drive(ext_rst_drive)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            boot_mode <= DEFAULT_MODE;
        end else if (enter_ph3) begin
            boot_mode <= cap.mode;
        end
    end

    assign reset_phase = phase;

    a_r4_change_at_ph3_entry: assert property (@(posedge clk) disable iff (rst)
        !$stable(boot_mode) |-> (phase == PH_THREE && $past(phase) == PH_TWO));

    a_r4_loads_capture: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_THREE && $past(phase) == PH_TWO) |-> (boot_mode == $past(cap.mode)));

    a_r1_known_mode: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(boot_mode));
endmodule

// File: tb/bootmode_capture_top_tb_top.sv
module bootmode_capture_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tb_pin_n = 1'b1;
    logic [3:0] req = '0;
    logic [3:0] mask = '0;
    logic [1:0] pins = 2'b00;
    logic [1:0] boot_mode;
    logic [1:0] reset_phase;
    logic       ext_rst_drive;
    logic       ext_pin_n;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    assign ext_pin_n = tb_pin_n & ~ext_rst_drive;

    bootmode_capture_top dut_i (
        .clk(clk), .rst(rst), .ext_rst_pin_n(ext_pin_n), .int_rst_req(req),
        .pin_drive_mask(mask), .boot_pins(pins), .boot_mode(boot_mode),
        .reset_phase(reset_phase), .ext_rst_drive(ext_rst_drive)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_phase(input string tag, input int target, input int maxc);
        bit hit = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (reset_phase == target[1:0]) begin hit = 1'b1; break; end
        end
        chk(tag, hit ? target : int'(reset_phase), target);
    endtask

    task automatic t_power_on;
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mode after reset", boot_mode, 0);
        chk("R1 drive after reset", ext_rst_drive, 0);
        chk("R1 phase after reset", reset_phase, 1);
        wait_phase("R7 reach phase 2", 2, 40);
        wait_phase("R7 reach phase 3", 3, 40);
        wait_phase("R1 back to run", 0, 40);
        chk("R1 default mode kept", boot_mode, 0);
    endtask

    task automatic t_pin_capture;
        pins = 2'b10;
        tb_pin_n = 1'b0;
        cyc(20);
        chk("R4 mode held during reset", boot_mode, 0);
        chk("R7 phase 1 during reset", reset_phase, 1);
        tb_pin_n = 1'b1;
        wait_phase("R7 phase 2 after release", 2, 60);
        chk("R4 mode held in phase 2", boot_mode, 0);
        wait_phase("R7 phase 3 after phase 2", 3, 20);
        chk("R4 mode loaded at phase 3", boot_mode, 2);
        wait_phase("R7 run after phase 3", 0, 20);
        chk("R2 captured strap", boot_mode, 2);
    endtask

    task automatic t_freeze(input int delay, input logic [1:0] late, input int exp);
        pins = 2'b01;
        tb_pin_n = 1'b0;
        cyc(10);
        tb_pin_n = 1'b1;
        cyc(delay);
        pins = late;
        wait_phase("R3 return to run", 0, 80);
        chk("R3 freeze point", boot_mode, exp);
    endtask

    task automatic t_unmasked;
        bit drove = 1'b0;
        mask = 4'b0000;
        pins = 2'b00;
        cyc(4);
        req = 4'b0010;
        @(negedge clk);
        req = 4'b0000;
        chk("R5 restart phase", reset_phase, 1);
        for (int i = 0; i < 60 && reset_phase != 2'd0; i++) begin
            if (ext_rst_drive) drove = 1'b1;
            @(negedge clk);
        end
        chk("R5 no pin drive", drove, 0);
        chk("R5 sequence done", reset_phase, 0);
        chk("R5 mode retained", boot_mode, 1);
    endtask

    task automatic t_masked;
        mask = 4'b0100;
        pins = 2'b11;
        cyc(4);
        req = 4'b1000;
        @(negedge clk);
        req = 4'b0000;
        chk("R6 unmasked source no drive", ext_rst_drive, 0);
        wait_phase("R6 settle", 0, 60);
        chk("R6 unmasked source keeps mode", boot_mode, 1);
        req = 4'b0100;
        @(negedge clk);
        req = 4'b0000;
        chk("R6 drive asserted", ext_rst_drive, 1);
        cyc(7);
        chk("R6 drive still on", ext_rst_drive, 1);
        @(negedge clk);
        chk("R6 drive released", ext_rst_drive, 0);
        wait_phase("R6 back to run", 0, 80);
        chk("R6 recaptured mode", boot_mode, 3);
    endtask

    initial begin
        t_power_on();
        t_pin_capture();
        t_freeze(8, 2'b11, 3);
        t_freeze(14, 2'b10, 1);
        t_unmasked();
        t_masked();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1-R7 actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule